// File: doc/BRIEF.md
# Three-Output Shared-Period PWM Timer

This block is a 16-bit up-counter that drives three pulse-width-modulated outputs from one common period. A cycle register sets the period: the counter runs from zero up to the cycle value and then returns to zero, so one period lasts the cycle value plus one counting step. Each output has its own duty register. An output is high from the start of a period through the count that matches its duty value, and low for the rest of the period.

The waveform is always a pulse. A duty of zero still gives a high pulse one count long. A duty at or above the cycle value is held off the final count of the period, so the output still drops once per period. The counter steps only when the external clock-enable input is high and software has set the run bit, so a prescaler outside the block sets the count rate. Two sticky status flags record the cycle compare-match and the counter passing through its all-ones value. Software clears each flag by writing a one to its clear bit. All registers are written through a simple synchronous write port, and a duty or cycle value can be changed while the counter runs.

Top module: `pwm3_timer`

## Requirements
- R1: A tick is a clock edge with `cnt_en`=1 while the run bit is set. On each tick the counter goes up by one. On a tick where the counter equals the cycle register, the counter goes to 0 instead. One period is therefore cycle+1 ticks. A count above the cycle value runs on to 16'hFFFF and then wraps to 0.
- R2: On an edge that is not a tick, the counter, the outputs and the flags (other than a clear) keep their values.
- R3: After each tick, `pwm_out[i]` is 1 exactly when the new count is at most duty register i and less than the cycle register. The comparison uses the register values from before that edge.
- R4: With a cycle value of at least 1 and duty 0, an output is high for exactly one count in each period, at count 0.
- R5: With a cycle value of at least 1, every output is high at count 0 and low at the count equal to the cycle value, whatever the duty values are. No output can reach 0% or 100% duty.
- R6: A duty register written while the counter runs is used from the next tick on.
- R7: The cycle flag `flag_cyc` sets on a tick where the count equals the cycle register. The overflow flag `flag_ovf` sets on a tick where the count is 16'hFFFF. With the cycle register at 16'hFFFF, both flags set on the same edge.
- R8: A flag stays set until a write to address 5 with a 1 in bit 0 (cycle flag) or bit 1 (overflow flag). If that write lands on the same edge as a set of the flag, the set wins.
- R9: Write addresses: 0 = control (bit 0 is the run bit), 1 = cycle, 2/3/4 = duty of outputs 0/1/2, 5 = flag clear. Writes to addresses 6 and 7 have no effect. After reset the counter is 0, the outputs are low, the flags are clear, the run bit is 0, the cycle register is 16'hFFFF and every duty register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable from an external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 3 | PWM outputs, one per duty register |
| cnt_value | output | 16 | Current counter value |
| flag_cyc | output | 1 | Sticky cycle compare-match flag |
| flag_ovf | output | 1 | Sticky counter overflow flag |

## Verification
A wrong count or a wrong wrap decision shows on `cnt_value` at the edge where it happens. It then spreads to all three outputs at that same edge, because each output is recomputed from the new count. A bad duty or cycle register shows as an output edge one count early or late within the current period. A flag that is lost, set too early or not held shows on the flag pins in the first cycle after the edge in question. The bench compares every port to a reference model after every clock edge, so each of these faults is reported in the cycle it first appears. The cycle-value-16'hFFFF case requires a full run through the count range and is driven directly.

// File: rtl/pwm3_pkg.sv
// Package: shared constants for the three-output PWM timer.
// Holds the counter width, the channel count, the write-port address width
// and the register address map used by the register file.
package pwm3_pkg;
    parameter int CNT_W  = 16;
    parameter int NUM_CH = 3;
    parameter int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CYCLE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_DUTY0 = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_FCLR  = 3'd5;

    localparam int FCLR_CYC_BIT = 0;
    localparam int FCLR_OVF_BIT = 1;
    localparam int CTRL_RUN_BIT = 0;
endpackage

// File: rtl/pwm3_regs.sv
// Module: pwm3_regs
// Register file for the PWM timer. It holds the run bit, the shared cycle
// register and one duty register per channel. It also decodes the flag-clear
// address into single-cycle clear pulses.
// Assumes: writes are single-cycle strobes. Unmapped addresses are dropped.
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              run,
    output logic [W-1:0]      cycle,
    output logic [N-1:0][W-1:0] duty,
    output logic              clr_cyc,
    output logic              clr_ovf
);
    logic sel_ctrl;
    logic sel_cycle;
    logic sel_fclr;

    // Address decode for the single-instance registers.
    always_comb begin
        sel_ctrl  = wr_en && (wr_addr == ADR_CTRL);
        sel_cycle = wr_en && (wr_addr == ADR_CYCLE);
        sel_fclr  = wr_en && (wr_addr == ADR_FCLR);
    end

    // Control register: the run bit gates counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (sel_ctrl) begin
            run <= wr_data[CTRL_RUN_BIT];
        end
    end

    // Cycle register: sets the period shared by all channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle <= '1;
        end else if (sel_cycle) begin
            cycle <= wr_data;
        end
    end

    // One duty register per channel, each at its own address.
    for (genvar i = 0; i < N; i++) begin : g_duty
        logic sel_duty;

        // Decode this channel's duty address.
        always_comb begin
            sel_duty = wr_en && (wr_addr == (ADR_DUTY0 + ADDR_W'(i)));
        end

        // Duty storage for channel i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty[i] <= '0;
            end else if (sel_duty) begin
                duty[i] <= wr_data;
            end
        end
    end

    // Flag-clear pulses. These are valid only in the cycle of the write.
    always_comb begin
        clr_cyc = sel_fclr && wr_data[FCLR_CYC_BIT];
        clr_ovf = sel_fclr && wr_data[FCLR_OVF_BIT];
    end
endmodule

// File: rtl/pwm3_counter.sv
// Module: pwm3_counter
// Up-counter that returns to zero on a tick where it equals the cycle value.
// It also gives the value the counter will take on the next tick, so the
// channels can register their outputs in step with the count.
// Assumes: tick is already the AND of run and the external clock enable.
module pwm3_counter
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cycle,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         cyc_match,
    output logic         at_max
);
    // Compare against the cycle value and the all-ones value, and form the
    // next count.
    always_comb begin
        cyc_match = (cnt == cycle);
        at_max    = (cnt == {W{1'b1}});
        cnt_next  = cyc_match ? '0 : cnt + 1'b1;
    end

    // Counter register. It advances only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/pwm3_flags.sv
// Module: pwm3_flags
// Sticky status flags for the cycle compare-match and the counter overflow.
// A set on the same edge as a software clear wins.
// Assumes: clear pulses last a single cycle.
module pwm3_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cyc_match,
    input  logic at_max,
    input  logic clr_cyc,
    input  logic clr_ovf,
    output logic flag_cyc,
    output logic flag_ovf
);
    logic set_cyc;
    logic set_ovf;

    // Set conditions are qualified by a tick.
    always_comb begin
        set_cyc = tick && cyc_match;
        set_ovf = tick && at_max;
    end

    // Cycle flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_cyc <= 1'b0;
        end else if (set_cyc) begin
            flag_cyc <= 1'b1;
        end else if (clr_cyc) begin
            flag_cyc <= 1'b0;
        end
    end

    // Overflow flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ovf <= 1'b0;
        end else if (set_ovf) begin
            flag_ovf <= 1'b1;
        end else if (clr_ovf) begin
            flag_ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm3_wave.sv
// Module: pwm3_wave
// Waveform stage for one output. On each tick the output is recomputed from
// the count about to be loaded: it is high while that count is at most the
// duty value and below the cycle value. This keeps the output low on the
// last count of every period and high on count zero.
// Assumes: cnt_next comes from the shared counter in the same cycle.
module pwm3_wave
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] cycle,
    output logic         pwm
);
    logic in_width;
    logic before_end;
    logic level;

    // Decide the level that goes with the next count.
    always_comb begin
        in_width   = (cnt_next <= duty);
        before_end = (cnt_next < cycle);
        level      = in_width && before_end;
    end

    // Output register. It holds between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (tick) begin
            pwm <= level;
        end
    end
endmodule

// File: rtl/pwm3_timer.sv
// Module: pwm3_timer (top)
// Three-output PWM timer with one shared period. It joins the register file,
// the counter, the status flags and one waveform stage per output.
// Assumes: cnt_en comes from an outside prescaler that is synchronous to clk.
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [N-1:0]      pwm_out,
    output logic [W-1:0]      cnt_value,
    output logic              flag_cyc,
    output logic              flag_ovf
);
    logic               run;
    logic [W-1:0]       cycle_q;
    logic [N-1:0][W-1:0] duty_q;
    logic               clr_cyc;
    logic               clr_ovf;
    logic               tick;
    logic [W-1:0]       cnt_next;
    logic               cyc_match;
    logic               at_max;

    // A tick needs both the run bit and the external enable.
    always_comb begin
        tick = run && cnt_en;
    end

    pwm3_regs #(.W(W), .N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (run),
        .cycle   (cycle_q),
        .duty    (duty_q),
        .clr_cyc (clr_cyc),
        .clr_ovf (clr_ovf)
    );

    pwm3_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cycle     (cycle_q),
        .cnt       (cnt_value),
        .cnt_next  (cnt_next),
        .cyc_match (cyc_match),
        .at_max    (at_max)
    );

    pwm3_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cyc_match (cyc_match),
        .at_max    (at_max),
        .clr_cyc   (clr_cyc),
        .clr_ovf   (clr_ovf),
        .flag_cyc  (flag_cyc),
        .flag_ovf  (flag_ovf)
    );

    for (genvar i = 0; i < N; i++) begin : g_ch
        pwm3_wave #(.W(W)) u_wave (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .cnt_next (cnt_next),
            .duty     (duty_q[i]),
            .cycle    (cycle_q),
            .pwm      (pwm_out[i])
        );
    end
endmodule

// File: rtl/pwm3_checker.sv
// Module: pwm3_checker
// Assertion checker bound to pwm3_timer. It watches the counter, the outputs
// and the flags against the tick and the register values.
module pwm3_checker #(
    parameter int W = 16,
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cycle,
    input logic [N-1:0] out,
    input logic         flag_cyc,
    input logic         flag_ovf,
    input logic         clr_cyc,
    input logic         clr_ovf
);
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cnt == cycle) |=> cnt == '0); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cnt != cycle) |=> cnt == $past(cnt) + 1'b1); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt) && $stable(out)); // R2
    AST_PERIOD_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cnt == cycle) && (cycle != '0) |=> out == '1); // R5
    AST_LAST_COUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cycle != '0) && ({1'b0, cnt} + 1'b1 == {1'b0, cycle}) |=> out == '0); // R5
    AST_FULL_RANGE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cnt == '1) && (cycle == '1) |=> flag_cyc && flag_ovf); // R7
    AST_CYC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_cyc && !clr_cyc |=> flag_cyc); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf && !clr_ovf |=> flag_ovf); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cnt == cycle) && clr_cyc |=> flag_cyc); // R8
endmodule

bind pwm3_timer pwm3_checker #(.W(W), .N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt      (cnt_value),
    .cycle    (cycle_q),
    .out      (pwm_out),
    .flag_cyc (flag_cyc),
    .flag_ovf (flag_ovf),
    .clr_cyc  (clr_cyc),
    .clr_ovf  (clr_ovf)
);

// File: tb/pwm3_timer_bench.sv
`timescale 1ns/1ps
module pwm3_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  pwm_out;
    logic [15:0] cnt_value;
    logic        flag_cyc;
    logic        flag_ovf;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    logic        m_run;
    logic [15:0] m_cycle;
    logic [15:0] m_duty [3];
    logic [15:0] m_cnt;
    logic [2:0]  m_out;
    logic        m_fc;
    logic        m_fo;

    always #2.5 clk = ~clk;

    pwm3_timer u_pwm3_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .cnt_value(cnt_value), .flag_cyc(flag_cyc), .flag_ovf(flag_ovf)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_out(input logic [15:0] c);
        logic [2:0] r;
        for (int i = 0; i < 3; i++) r[i] = (c <= m_duty[i]) && (c < m_cycle);
        return r;
    endfunction

    task automatic model_reset();
        m_run = 0; m_cycle = 16'hFFFF; m_cnt = 0; m_out = 0; m_fc = 0; m_fo = 0;
        for (int i = 0; i < 3; i++) m_duty[i] = 0;
    endtask

    // One model step for an edge with the given inputs (uses pre-edge state).
    task automatic model_step(input logic en, input logic we, input logic [2:0] a, input logic [15:0] d);
        logic tk, wrap, top, cc, co;
        logic [15:0] nc;
        tk = m_run && en;
        wrap = (m_cnt == m_cycle);
        top = (m_cnt == 16'hFFFF);
        cc = we && (a == 3'd5) && d[0];
        co = we && (a == 3'd5) && d[1];
        if (tk) begin
            nc = wrap ? 16'd0 : m_cnt + 16'd1;
            m_out = exp_out(nc);
            m_cnt = nc;
        end
        m_fc = (tk && wrap) ? 1'b1 : (cc ? 1'b0 : m_fc);
        m_fo = (tk && top) ? 1'b1 : (co ? 1'b0 : m_fo);
        if (we) begin
            case (a)
                3'd0: m_run = d[0];
                3'd1: m_cycle = d;
                3'd2: m_duty[0] = d;
                3'd3: m_duty[1] = d;
                3'd4: m_duty[2] = d;
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        chk(cnt_value == m_cnt, "R1 count", 32'(cnt_value), 32'(m_cnt));
        chk(pwm_out == m_out, "R3 outputs", 32'(pwm_out), 32'(m_out));
        chk({flag_cyc, flag_ovf} == {m_fc, m_fo}, "R7 flags", 32'({flag_cyc, flag_ovf}), 32'({m_fc, m_fo}));
    endtask

    task automatic cyc(input logic en, input logic we, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cnt_en = en; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(en, we, a, d);
        #1;
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int highs0, highs2;
        logic [15:0] hold;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(cnt_value == 0 && pwm_out == 0 && !flag_cyc && !flag_ovf, "R9 reset",
            32'({cnt_value, pwm_out, flag_cyc, flag_ovf}), 32'd0);

        // R2: enable without run bit does nothing
        repeat (4) cyc(1'b1, 1'b0, 3'd0, 16'd0);
        chk(cnt_value == 0, "R2 no run", 32'(cnt_value), 32'd0);

        // Setup: cycle 5, duty0 0, duty1 2, duty2 0xFFFF, run
        wr(3'd1, 16'd5); wr(3'd2, 16'd0); wr(3'd3, 16'd2); wr(3'd4, 16'hFFFF); wr(3'd0, 16'd1);
        // Align to start of a period
        while (cnt_value != 16'd5) cyc(1'b1, 1'b0, 3'd0, 16'd0);
        chk(pwm_out == 3'b000, "R5 last count low", 32'(pwm_out), 32'd0);
        highs0 = 0; highs2 = 0;
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, 1'b0, 3'd0, 16'd0);
            if (k == 0) chk(pwm_out == 3'b111, "R5 count zero high", 32'(pwm_out), 32'h7);
            highs0 += int'(pwm_out[0]);
            highs2 += int'(pwm_out[2]);
        end
        chk(highs0 == 1, "R4 one-count pulse", 32'(highs0), 32'd1);
        chk(highs2 == 5, "R5 capped width", 32'(highs2), 32'd5);

        // R2: stall holds state
        hold = cnt_value;
        repeat (3) cyc(1'b0, 1'b0, 3'd0, 16'd0);
        chk(cnt_value == hold, "R2 stall hold", 32'(cnt_value), 32'(hold));

        // R6: change duty1 from 2 to 4 while running
        cyc(1'b1, 1'b1, 3'd3, 16'd4);
        while (cnt_value != 16'd3) cyc(1'b1, 1'b0, 3'd0, 16'd0);
        chk(pwm_out[1] == 1'b1, "R6 new duty used", 32'(pwm_out[1]), 32'd1);

        // R8: clear flags, then clear on the same edge as a set
        wr(3'd5, 16'd3);
        chk(!flag_cyc && !flag_ovf, "R8 clear", 32'({flag_cyc, flag_ovf}), 32'd0);
        while (cnt_value != 16'd5) cyc(1'b1, 1'b0, 3'd0, 16'd0);
        cyc(1'b1, 1'b1, 3'd5, 16'd1);
        chk(flag_cyc == 1'b1, "R8 set wins", 32'(flag_cyc), 32'd1);

        // R9: unmapped addresses ignored
        hold = cnt_value;
        cyc(1'b0, 1'b1, 3'd6, 16'd0);
        cyc(1'b0, 1'b1, 3'd7, 16'd0);
        chk(cnt_value == hold && cnt_value == m_cnt, "R9 unmapped write", 32'(cnt_value), 32'(hold));
        repeat (8) cyc(1'b1, 1'b0, 3'd0, 16'd0);

        // Random phase: small periods, random enables and writes
        for (int k = 0; k < 3000; k++) begin
            logic en, we;
            logic [2:0] a;
            logic [15:0] d;
            en = ($urandom % 4) != 0;
            we = ($urandom % 5) == 0;
            a = 3'($urandom % 8);
            case (a)
                3'd0: d = 16'(($urandom % 8) != 0);
                3'd1: d = 16'($urandom % 13);
                3'd5: d = 16'($urandom % 4);
                default: d = 16'($urandom % 15);
            endcase
            cyc(en, we, a, d);
        end

        // R7: full-range period, both flags set on one edge
        wr(3'd1, 16'hFFFF); wr(3'd0, 16'd1); wr(3'd5, 16'd3);
        while (cnt_value != 16'hFFFF) cyc(1'b1, 1'b0, 3'd0, 16'd0);
        chk(!flag_cyc && !flag_ovf, "R7 before top", 32'({flag_cyc, flag_ovf}), 32'd0);
        cyc(1'b1, 1'b0, 3'd0, 16'd0);
        chk(flag_cyc && flag_ovf && cnt_value == 0, "R7 both flags",
            32'({flag_cyc, flag_ovf}), 32'h3);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule